// File: doc/BRIEF.md
# PCIe Interrupt Collector (INTx levels and MSI doorbell)

This block gathers the interrupt sources of one PCIe root complex and drives a single level-sensitive host interrupt line. Four legacy INTx wires are copied into the low bits of an interrupt status register. That register also holds a transaction-done flag, set by a pulse from the configuration engine. An enable register gates the status register, and any enabled bit that is set raises the host line.

MSI traffic arrives on a 32-bit doorbell write port. The written value is a vector number, and it sets one bit in one of two 32-bit MSI status banks. Any accepted doorbell raises the host line. Software reads and clears the status through a small word-addressed register port. Clears follow specific rules. A zero write does nothing. An all-ones write scrubs a bank and leaves the line alone. Writes to the INTx field of the interrupt status register have no effect on it.

Top module: `pcie_irq_collector`

## Requirements
- R1: Status bits [3:0] of the interrupt status register (address 1) equal the levels of `intx_i` sampled at the previous clock edge.
- R2: `irq_o` is high when the 5-bit AND of interrupt status and interrupt enable (address 0, bits [4:0] read/write) is non-zero, or when the MSI line is held. It is low when neither condition holds, one cycle after the causing input.
- R3: A doorbell with `db_be_i` = 4'b1111 and a value v below 64 sets bit v of MSI bank 0 (address 2) when v < 32, and otherwise sets bit v-32 of MSI bank 1 (address 3). It also raises `irq_o`.
- R4: A full-width doorbell with a value of 64 or more changes no status. It raises `db_err_o` for exactly one cycle, in the cycle after the write.
- R5: A doorbell whose byte enables are not all set is ignored: no status bit, no `irq_o` change, and no error.
- R6: Writing zero to an MSI bank leaves that bank and `irq_o` unchanged.
- R7: Any other write to an MSI bank clears the bits that are set in the data. If both banks are then zero and the data was not all ones, the MSI line is dropped.
- R8: Writing all ones to an MSI bank clears it and leaves the MSI line, and so `irq_o`, unchanged.
- R9: A write to address 1 clears bit 4 (the done flag) when data bit 4 is set, and leaves bits [3:0] unaffected.
- R10: A one-cycle pulse on `xfer_done_i` sets bit 4 of the interrupt status register.
- R11: When a doorbell sets a bit and a software write clears the same bit in the same cycle, the bit ends up set.
- R12: Synchronous reset clears the enable and all status registers, the MSI line, `db_err_o` and `irq_o`.
- R13: `reg_rdata_o` shows the register selected by `reg_addr_i`, registered. The value appears one clock after the address is applied and reflects all writes from earlier edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| intx_i | input | 4 | Legacy INTx levels |
| xfer_done_i | input | 1 | Configuration transaction finished pulse |
| db_valid_i | input | 1 | Doorbell write strobe |
| db_be_i | input | 4 | Doorbell byte enables |
| db_data_i | input | 32 | Doorbell data (MSI vector number) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Host interrupt line |
| db_err_o | output | 1 | Out-of-range doorbell pulse |

## Verification
Every state change lands on the edge that samples its input. `irq_o` and `db_err_o` are registered from the next-state values, so both are due one cycle after the stimulus. Read data passes through one more register, so a status value shows on `reg_rdata_o` two edges after the stimulus that changed it. The bench drives each stimulus for one cycle on a falling edge. It then selects the register of interest and waits one rising edge before it samples `irq_o` and `reg_rdata_o` on the following falling edge. The error pulse is sampled both in the cycle it is due and in the cycle after, so that its one-cycle width is checked.

// File: rtl/irq_col_pkg.sv
package irq_col_pkg;
  localparam int unsigned ADDR_W = 2;
  // word addresses of the software-visible registers
  localparam logic [ADDR_W-1:0] A_EN   = 2'd0;
  localparam logic [ADDR_W-1:0] A_STS  = 2'd1;
  localparam logic [ADDR_W-1:0] A_MSI0 = 2'd2;
endpackage

// File: rtl/irq_col_intx.sv
module irq_col_intx
  import irq_col_pkg::*;
#(
  parameter int unsigned INTX_N = 4,
  localparam int unsigned STS_W = INTX_N + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INTX_N-1:0] intx_i,
  input  logic              done_i,
  input  logic              we_en,
  input  logic              we_sts,
  input  logic [STS_W-1:0]  wdata,
  output logic [STS_W-1:0]  en_o,
  output logic [STS_W-1:0]  sts_o,
  output logic              hit_nxt_o
);
  logic [STS_W-1:0] en_q, en_nxt;
  logic [STS_W-1:0] sts_q, sts_nxt;
  logic             done_nxt;

  always_comb begin
    en_nxt   = we_en ? wdata : en_q;
    // done flag: pulse sets, write-one clears, set wins
    done_nxt = done_i | (sts_q[INTX_N] & ~(we_sts & wdata[INTX_N]));
    sts_nxt  = {done_nxt, intx_i};
    hit_nxt_o = |(sts_nxt & en_nxt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      sts_q <= '0;
    end else begin
      en_q  <= en_nxt;
      sts_q <= sts_nxt;
    end
  end

  assign en_o  = en_q;
  assign sts_o = sts_q;

  // R1
  intx_track_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> sts_q[INTX_N-1:0] == $past(intx_i));

  // R9
  done_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (we_sts && wdata[INTX_N] && !done_i) |=> !sts_q[INTX_N]);

  // R10
  done_set_chk: assert property (@(posedge clk) disable iff (rst)
    done_i |=> sts_q[INTX_N]);
endmodule

// File: rtl/irq_col_msi.sv
module irq_col_msi
  import irq_col_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned MSI_VEC = 64,
  localparam int unsigned NBANK  = MSI_VEC / DATA_W,
  localparam int unsigned VEC_W  = $clog2(MSI_VEC),
  localparam int unsigned LANE_W = $clog2(DATA_W),
  localparam int unsigned BIDX_W = VEC_W - LANE_W,
  localparam int unsigned BE_W   = DATA_W / 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         db_valid,
  input  logic [BE_W-1:0]              db_be,
  input  logic [DATA_W-1:0]            db_data,
  input  logic                         we,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  output logic [NBANK-1:0][DATA_W-1:0] banks_o,
  output logic                         line_nxt_o,
  output logic                         err_o
);
  logic [NBANK-1:0][DATA_W-1:0] bank_q, bank_nxt;
  logic [NBANK-1:0]             clr_hit;
  logic [NBANK-1:0]             nz;
  logic                         full_wr, in_range, acc, bad;
  logic                         line_q, drop, err_q;
  logic [LANE_W-1:0]            lane;
  logic [BIDX_W-1:0]            bidx;
  logic                         wr_ones;

  assign full_wr  = db_valid && (db_be == '1);
  assign in_range = (db_data[DATA_W-1:VEC_W] == '0);
  assign acc      = full_wr && in_range;
  assign bad      = full_wr && !in_range;
  assign lane     = db_data[LANE_W-1:0];
  assign bidx     = db_data[VEC_W-1:LANE_W];
  assign wr_ones  = (wdata == '1);

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(A_MSI0 + g);
    logic [DATA_W-1:0] set_v, clr_v;

    always_comb begin
      clr_hit[g] = we && (addr == MY_ADDR) && (wdata != '0);
      clr_v      = clr_hit[g] ? wdata : '0;
      set_v      = '0;
      if (acc && bidx == BIDX_W'(g)) set_v[lane] = 1'b1;
      bank_nxt[g] = (bank_q[g] & ~clr_v) | set_v;
      nz[g]       = |bank_nxt[g];
    end

    always_ff @(posedge clk) begin
      if (rst) bank_q[g] <= '0;
      else     bank_q[g] <= bank_nxt[g];
    end

    // R6
    zero_wr_chk: assert property (@(posedge clk) disable iff (rst)
      (we && addr == MY_ADDR && wdata == '0 && !acc) |=> $stable(bank_q[g]));

    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      (acc && bidx == BIDX_W'(g) && clr_hit[g]) |=> (bank_q[g] != '0));
  end

  assign drop       = (|clr_hit) && !wr_ones && !(|nz);
  assign line_nxt_o = acc | (line_q & ~drop);

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      line_q <= line_nxt_o;
      err_q  <= bad;
    end
  end

  assign banks_o = bank_q;
  assign err_o   = err_q;

  // R3
  db_line_chk: assert property (@(posedge clk) disable iff (rst)
    acc |=> line_q);

  // R4
  bad_err_chk: assert property (@(posedge clk) disable iff (rst)
    bad |=> (err_q && $stable(bank_q)));

  // R8
  ones_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (we && wr_ones && (|clr_hit)) |=> !$fell(line_q));
endmodule

// File: rtl/irq_col_regs.sv
module irq_col_regs
  import irq_col_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned STS_W  = 5,
  parameter int unsigned NBANK  = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [STS_W-1:0]             en,
  input  logic [STS_W-1:0]             sts,
  input  logic [NBANK-1:0][DATA_W-1:0] banks,
  output logic [DATA_W-1:0]            rdata_o
);
  logic [DATA_W-1:0] rd_nxt, rd_q;

  always_comb begin
    rd_nxt = '0;
    if (addr == A_EN)  rd_nxt[STS_W-1:0] = en;
    if (addr == A_STS) rd_nxt[STS_W-1:0] = sts;
    for (int g = 0; g < NBANK; g++) begin
      if (addr == ADDR_W'(A_MSI0 + g)) rd_nxt = banks[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_nxt;
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/pcie_irq_collector.sv
module pcie_irq_collector
  import irq_col_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned INTX_N  = 4,
  parameter int unsigned MSI_VEC = 64,
  localparam int unsigned STS_W  = INTX_N + 1,
  localparam int unsigned NBANK  = MSI_VEC / DATA_W,
  localparam int unsigned BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INTX_N-1:0] intx_i,
  input  logic              xfer_done_i,
  input  logic              db_valid_i,
  input  logic [BE_W-1:0]   db_be_i,
  input  logic [DATA_W-1:0] db_data_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              db_err_o
);
  logic [STS_W-1:0]             en, sts;
  logic                         hit_nxt, line_nxt;
  logic [NBANK-1:0][DATA_W-1:0] banks;
  logic                         irq_q;

  irq_col_intx #(.INTX_N(INTX_N)) u_intx (
    .clk       (clk),
    .rst       (rst),
    .intx_i    (intx_i),
    .done_i    (xfer_done_i),
    .we_en     (reg_we_i && reg_addr_i == A_EN),
    .we_sts    (reg_we_i && reg_addr_i == A_STS),
    .wdata     (reg_wdata_i[STS_W-1:0]),
    .en_o      (en),
    .sts_o     (sts),
    .hit_nxt_o (hit_nxt)
  );

  irq_col_msi #(.DATA_W(DATA_W), .MSI_VEC(MSI_VEC)) u_msi (
    .clk        (clk),
    .rst        (rst),
    .db_valid   (db_valid_i),
    .db_be      (db_be_i),
    .db_data    (db_data_i),
    .we         (reg_we_i),
    .addr       (reg_addr_i),
    .wdata      (reg_wdata_i),
    .banks_o    (banks),
    .line_nxt_o (line_nxt),
    .err_o      (db_err_o)
  );

  irq_col_regs #(.DATA_W(DATA_W), .STS_W(STS_W), .NBANK(NBANK)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .addr    (reg_addr_i),
    .en      (en),
    .sts     (sts),
    .banks   (banks),
    .rdata_o (reg_rdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= hit_nxt | line_nxt;
  end

  assign irq_o = irq_q;

  // R12
  rst_quiet_chk: assert property (@(posedge clk)
    rst |=> (!irq_o && !db_err_o));

  // R2
  gate_chk: assert property (@(posedge clk) disable iff (rst)
    ((sts & en) != '0) |-> irq_o);
endmodule

// File: tb/test_pcie_irq_collector.sv
module test_pcie_irq_collector;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 17;
  // {op, addr, data, chk_addr, chk_val, irq}; op 0=doorbell 1=reg write 2=intx
  localparam logic [70:0] VEC [0:NVEC-1] = '{
    {2'd1, 2'd0, 32'h0000_001F, 2'd0, 32'h0000_001F, 1'b0},
    {2'd2, 2'd0, 32'h0000_0005, 2'd1, 32'h0000_0005, 1'b1},
    {2'd2, 2'd0, 32'h0000_0000, 2'd1, 32'h0000_0000, 1'b0},
    {2'd0, 2'd0, 32'd3,         2'd2, 32'h0000_0008, 1'b1},
    {2'd0, 2'd0, 32'd40,        2'd3, 32'h0000_0100, 1'b1},
    {2'd1, 2'd2, 32'h0000_0000, 2'd2, 32'h0000_0008, 1'b1},
    {2'd1, 2'd2, 32'h0000_0008, 2'd2, 32'h0000_0000, 1'b1},
    {2'd1, 2'd3, 32'h0000_0100, 2'd3, 32'h0000_0000, 1'b0},
    {2'd0, 2'd0, 32'd63,        2'd3, 32'h8000_0000, 1'b1},
    {2'd1, 2'd3, 32'hFFFF_FFFF, 2'd3, 32'h0000_0000, 1'b1},
    {2'd1, 2'd2, 32'h0000_0001, 2'd2, 32'h0000_0000, 1'b0},
    {2'd2, 2'd0, 32'h0000_0002, 2'd1, 32'h0000_0002, 1'b1},
    {2'd1, 2'd1, 32'hFFFF_FFFF, 2'd1, 32'h0000_0002, 1'b1},
    {2'd2, 2'd0, 32'h0000_0000, 2'd1, 32'h0000_0000, 1'b0},
    {2'd1, 2'd0, 32'h0000_0000, 2'd0, 32'h0000_0000, 1'b0},
    {2'd2, 2'd0, 32'h0000_000F, 2'd1, 32'h0000_000F, 1'b0},
    {2'd2, 2'd0, 32'h0000_0000, 2'd1, 32'h0000_0000, 1'b0}
  };
  localparam string VREQ [0:NVEC-1] = '{
    "R13", "R1 R2", "R1 R2", "R3", "R3", "R6", "R7", "R7", "R3",
    "R8", "R7", "R1", "R9", "R2", "R13", "R2", "R1"
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  intx_i = '0;
  logic        xfer_done_i = 1'b0;
  logic        db_valid_i = 1'b0;
  logic [3:0]  db_be_i = '0;
  logic [31:0] db_data_i = '0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o, db_err_o;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcie_irq_collector i_pcie_irq_collector (
    .clk(clk), .rst(rst), .intx_i(intx_i), .xfer_done_i(xfer_done_i),
    .db_valid_i(db_valid_i), .db_be_i(db_be_i), .db_data_i(db_data_i),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o), .db_err_o(db_err_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      check("watchdog", 32'd1, 32'd0);
      finish_run();
    end
  end

  // one-cycle stimulus helpers, all driven at the falling edge
  task automatic clear_strobes();
    db_valid_i = 1'b0; reg_we_i = 1'b0; xfer_done_i = 1'b0;
  endtask

  task automatic doorbell(input logic [3:0] be, input logic [31:0] v);
    db_valid_i = 1'b1; db_be_i = be; db_data_i = v;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
  endtask

  // after stimulus edge: select register, one edge for read data, sample
  task automatic observe(input logic [1:0] a, input string req,
                         input logic [31:0] val, input logic irq_exp);
    @(negedge clk); clear_strobes(); reg_addr_i = a;
    @(posedge clk); @(negedge clk);
    check(req, reg_rdata_o, val);
    check(req, {31'd0, irq_o}, {31'd0, irq_exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12: reset state of every register and output
    for (int a = 0; a < 4; a++) begin
      reg_addr_i = 2'(a);
      @(posedge clk); @(negedge clk);
      check("R12 reset reg", reg_rdata_o, 32'd0);
    end
    check("R12 reset irq", {31'd0, irq_o}, 32'd0);
    check("R12 reset err", {31'd0, db_err_o}, 32'd0);

    // table of vectors
    for (int i = 0; i < NVEC; i++) begin
      logic [1:0]  op, ad, ca;
      logic [31:0] dt, cv;
      logic        ie;
      {op, ad, dt, ca, cv, ie} = VEC[i];
      @(negedge clk);
      case (op)
        2'd0: doorbell(4'hF, dt);
        2'd1: wr(ad, dt);
        default: intx_i = dt[3:0];
      endcase
      @(posedge clk);
      observe(ca, VREQ[i], cv, ie);
    end

    // R4: out-of-range vector, one-cycle error pulse, no status change
    @(negedge clk); doorbell(4'hF, 32'd64);
    @(negedge clk); clear_strobes();
    check("R4 err pulse", {31'd0, db_err_o}, 32'd1);
    check("R4 irq", {31'd0, irq_o}, 32'd0);
    @(negedge clk);
    check("R4 err width", {31'd0, db_err_o}, 32'd0);
    observe(2'd2, "R4 bank0", 32'd0, 1'b0);
    observe(2'd3, "R4 bank1", 32'd0, 1'b0);

    // R5: partial byte enables ignored
    @(negedge clk); doorbell(4'h7, 32'd1);
    @(negedge clk); clear_strobes();
    check("R5 no err", {31'd0, db_err_o}, 32'd0);
    observe(2'd2, "R5 bank0", 32'd0, 1'b0);

    // R10 / R9: done flag set by pulse, cleared by write-one
    @(negedge clk); wr(2'd0, 32'h10);
    @(negedge clk); clear_strobes(); xfer_done_i = 1'b1;
    @(posedge clk);
    observe(2'd1, "R10 done set", 32'h10, 1'b1);
    @(negedge clk); wr(2'd1, 32'h10);
    @(posedge clk);
    observe(2'd1, "R9 done clear", 32'h0, 1'b0);

    // R11: set and clear on the same bit in one cycle
    @(negedge clk); doorbell(4'hF, 32'd5);
    @(posedge clk);
    observe(2'd2, "R11 prep", 32'h20, 1'b1);
    @(negedge clk); doorbell(4'hF, 32'd5); wr(2'd2, 32'h20);
    @(posedge clk);
    observe(2'd2, "R11 set wins", 32'h20, 1'b1);

    // R12: reset in mid-run clears status and line
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R12 irq after reset", {31'd0, irq_o}, 32'd0);
    observe(2'd2, "R12 bank0", 32'd0, 1'b0);
    observe(2'd0, "R12 enable", 32'd0, 1'b0);

    finish_run();
  end
endmodule